// File: doc/BRIEF.md
# Timer Compare-Match Output Unit

An 8-bit timer/counter with a single compare channel. It produces one waveform bit, and that bit can take over a general-purpose I/O pin. The counter advances only on cycles where a prescaler tick is high. A 2-bit waveform mode selects the counting sequence:

- free-running up count,
- clear-on-compare,
- fast PWM, which wraps at the top value,
- phase-correct PWM, which counts up and then down.

On every counting tick the counter is compared with an 8-bit compare value. When they are equal, a 2-bit output action field decides what happens to the internal waveform bit: set, clear, toggle, or one of the PWM polarities. The action field is sampled at the match itself. Changing the field therefore alters the waveform bit only at the next match, or at once through a force strobe in the non-PWM modes.

When the action field is nonzero, the waveform bit replaces the port data bit on the pin path. The pin direction always follows the data-direction input. Software can therefore preset the waveform bit with the force strobe while the pin is still an input, and then switch the pin to output at a known level.

Top module: `tmr_cmp_out`

## Requirements
- R1: While `rst_n` is low, `cnt_o` is 0 and `ocb_o` is 0. The phase-correct direction flag resets to "up".
- R2: On a cycle with `tick` low, `cnt_o` keeps its value at the next clock edge, in every waveform mode.
- R3: With `wave_mode` 2'b00 (free-running) or 2'b10 (fast PWM), each tick adds one to the counter, and 0xFF wraps to 0x00.
- R4: With `wave_mode` 2'b01 (clear-on-compare), a tick with `cnt_o == cmp_val` loads 0. Any other tick adds one.
- R5: With `wave_mode` 2'b11 (phase-correct), the counter counts up to 0xFF and then down to 0x00, and repeats. The end values are not held for an extra tick: 0xFF is followed by 0xFE, and 0x00 reached while counting down is followed by 0x01. In every other mode the direction flag is forced to "up".
- R6: In modes 2'b00 and 2'b01, a tick with `cnt_o == cmp_val` updates `ocb_o` according to `out_mode`:
  - 2'b01 toggles it,
  - 2'b10 clears it,
  - 2'b11 sets it,
  - 2'b00 leaves it unchanged.
- R7: In fast PWM, with `out_mode` 2'b10:
  - a tick that matches clears `ocb_o`,
  - a non-matching tick while `cnt_o` is 0x00 sets it.

  With `out_mode` 2'b11 the two actions are reversed. A match takes precedence over the 0x00 event. With `out_mode` 2'b00 or 2'b01, `ocb_o` does not change.
- R8: In phase-correct PWM, with `out_mode` 2'b10:
  - a match while the direction flag is "up" clears `ocb_o`,
  - a match while it is "down" sets it.

  With `out_mode` 2'b11 the two actions are reversed. With `out_mode` 2'b00 or 2'b01, `ocb_o` does not change.
- R9: In modes 2'b00 and 2'b01, `force_stb` applies the R6 action of `out_mode` to `ocb_o` at the next edge, whether or not a tick or a match is present. The action is applied exactly once. The force does not alter the counter.
- R10: In modes 2'b10 and 2'b11, `force_stb` has no effect.
- R11: When `out_mode` is nonzero, `pin_val_o` equals `ocb_o`. When `out_mode` is zero, `pin_val_o` equals `port_data`. This holds regardless of `wave_mode`.
- R12: `pin_oe_o` always equals `port_dir`.
- R13: Without a tick or a force, `ocb_o` keeps its value, even when `out_mode`, `wave_mode` or `cmp_val` change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable from the prescaler |
| wave_mode | input | 2 | Counting sequence: 00 free, 01 clear-on-compare, 10 fast PWM, 11 phase-correct |
| out_mode | input | 2 | Compare output action / PWM polarity |
| cmp_val | input | 8 | Compare value |
| force_stb | input | 1 | Force-compare strobe (non-PWM modes only) |
| port_data | input | 1 | Normal port data bit |
| port_dir | input | 1 | Data-direction bit, 1 = output |
| cnt_o | output | 8 | Counter value |
| ocb_o | output | 1 | Internal waveform bit |
| pin_val_o | output | 1 | Value presented to the pin driver |
| pin_oe_o | output | 1 | Pin output enable |

## Verification
The bench targets the turnarounds at 0xFF and 0x00 in phase-correct mode. A design that holds an end value for two ticks, or leaves the direction flag stale, drifts one count and swaps the polarity of every later match.

It forces a strobe in the same cycle as a toggle match; a design that applied both actions would leave the bit unchanged. It also sets the compare value to 0x00 in fast PWM, where the match and the bottom event coincide and the wrong priority gives the opposite level.

Finally, it changes `out_mode` between matches and forces while in PWM. A design that acts on a field write, or honours the strobe in PWM, shows a waveform edge where none is due.

// File: rtl/tmr_cmp_pkg.sv
package tmr_cmp_pkg;

    typedef enum logic [1:0] {
        WG_NORMAL = 2'b00,
        WG_CTC    = 2'b01,
        WG_FAST   = 2'b10,
        WG_PHASE  = 2'b11
    } wg_mode_e;

    typedef enum logic [1:0] {
        CO_OFF    = 2'b00,
        CO_TOGGLE = 2'b01,
        CO_CLEAR  = 2'b10,
        CO_SET    = 2'b11
    } co_mode_e;

    // Non-PWM compare action applied to the current waveform bit.
    function automatic logic nonpwm_act(input co_mode_e mode, input logic cur);
        logic res;
        unique case (mode)
            CO_OFF:    res = cur;
            CO_TOGGLE: res = ~cur;
            CO_CLEAR:  res = 1'b0;
            CO_SET:    res = 1'b1;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/tmr_cnt_seq.sv
module tmr_cnt_seq
    import tmr_cmp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  wg_mode_e         wave_mode,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] cnt_o,
    output logic             up_o,
    output logic             match_o
);
    localparam logic [CNT_W-1:0] TOP = '1;
    localparam logic [CNT_W-1:0] BOT = '0;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             up;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        match_o = tick && (st_q.cnt == cmp_val);
        if (wave_mode != WG_PHASE) begin
            st_d.up = 1'b1;
        end
        if (tick) begin
            unique case (wave_mode)
                WG_NORMAL, WG_FAST: st_d.cnt = st_q.cnt + ONE;
                WG_CTC:             st_d.cnt = match_o ? BOT : st_q.cnt + ONE;
                WG_PHASE: begin
                    if (st_q.up) begin
                        if (st_q.cnt == TOP) begin
                            st_d.cnt = TOP - ONE;
                            st_d.up  = 1'b0;
                        end else begin
                            st_d.cnt = st_q.cnt + ONE;
                        end
                    end else begin
                        if (st_q.cnt == BOT) begin
                            st_d.cnt = ONE;
                            st_d.up  = 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt - ONE;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= BOT;
            st_q.up  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
    assign up_o  = st_q.up;

endmodule

// File: rtl/tmr_wave_gen.sv
module tmr_wave_gen
    import tmr_cmp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  wg_mode_e         wave_mode,
    input  co_mode_e         out_mode,
    input  logic             force_stb,
    input  logic             match,
    input  logic [CNT_W-1:0] cnt,
    input  logic             up,
    output logic             ocb_o
);
    localparam logic [CNT_W-1:0] BOT = '0;

    typedef struct packed {
        logic ocb;
    } wave_st_t;

    wave_st_t st_d, st_q;
    logic     pwm_mode;
    logic     pwm_sel;

    always_comb begin
        st_d     = st_q;
        pwm_mode = (wave_mode == WG_FAST) || (wave_mode == WG_PHASE);
        pwm_sel  = (out_mode == CO_CLEAR) || (out_mode == CO_SET);
        if (force_stb && !pwm_mode) begin
            st_d.ocb = nonpwm_act(out_mode, st_q.ocb);
        end else if (tick) begin
            unique case (wave_mode)
                WG_NORMAL, WG_CTC: begin
                    if (match) st_d.ocb = nonpwm_act(out_mode, st_q.ocb);
                end
                WG_FAST: begin
                    if (pwm_sel) begin
                        if (match)           st_d.ocb = (out_mode == CO_SET);
                        else if (cnt == BOT) st_d.ocb = (out_mode == CO_CLEAR);
                    end
                end
                WG_PHASE: begin
                    if (pwm_sel && match) begin
                        st_d.ocb = up ? (out_mode == CO_SET) : (out_mode == CO_CLEAR);
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.ocb <= 1'b0;
        else        st_q     <= st_d;
    end

    assign ocb_o = st_q.ocb;

endmodule

// File: rtl/tmr_pin_mux.sv
module tmr_pin_mux
    import tmr_cmp_pkg::*;
(
    input  co_mode_e out_mode,
    input  logic     ocb,
    input  logic     port_data,
    input  logic     port_dir,
    output logic     pin_val_o,
    output logic     pin_oe_o
);
    logic takeover;

    always_comb begin
        takeover  = (out_mode != CO_OFF);
        pin_val_o = takeover ? ocb : port_data;
        pin_oe_o  = port_dir;
    end

endmodule

// File: rtl/tmr_cmp_out.sv
module tmr_cmp_out
    import tmr_cmp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [1:0]       wave_mode,
    input  logic [1:0]       out_mode,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             force_stb,
    input  logic             port_data,
    input  logic             port_dir,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ocb_o,
    output logic             pin_val_o,
    output logic             pin_oe_o
);
    wg_mode_e         wm;
    co_mode_e         om;
    logic [CNT_W-1:0] cnt;
    logic             up;
    logic             match;
    logic             ocb;

    assign wm = wg_mode_e'(wave_mode);
    assign om = co_mode_e'(out_mode);

    tmr_cnt_seq #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .wave_mode (wm),
        .cmp_val   (cmp_val),
        .cnt_o     (cnt),
        .up_o      (up),
        .match_o   (match)
    );

    tmr_wave_gen #(.CNT_W(CNT_W)) u_wave (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .wave_mode (wm),
        .out_mode  (om),
        .force_stb (force_stb),
        .match     (match),
        .cnt       (cnt),
        .up        (up),
        .ocb_o     (ocb)
    );

    tmr_pin_mux u_pin (
        .out_mode  (om),
        .ocb       (ocb),
        .port_data (port_data),
        .port_dir  (port_dir),
        .pin_val_o (pin_val_o),
        .pin_oe_o  (pin_oe_o)
    );

    assign cnt_o = cnt;
    assign ocb_o = ocb;

endmodule

// File: rtl/tmr_cmp_out_chk.sv
module tmr_cmp_out_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [1:0]       wave_mode,
    input logic [1:0]       out_mode,
    input logic [CNT_W-1:0] cmp_val,
    input logic             force_stb,
    input logic             port_data,
    input logic             port_dir,
    input logic [CNT_W-1:0] cnt_o,
    input logic             ocb_o,
    input logic             pin_val_o,
    input logic             pin_oe_o
);
    localparam logic [CNT_W-1:0] TOP = '1;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_o));

    assert_free_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && wave_mode == 2'b00) |=> (cnt_o == $past(cnt_o) + ONE));

    assert_ctc_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && wave_mode == 2'b01 && cnt_o == cmp_val) |=> (cnt_o == '0));

    assert_phase_turn_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && wave_mode == 2'b11 && cnt_o == TOP) |=> (cnt_o == TOP - ONE));

    assert_pwm_force_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && force_stb && wave_mode[1]) |=> $stable(ocb_o));

    assert_ocb_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !force_stb) |=> $stable(ocb_o));

    assert_pin_override_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode != 2'b00) |-> (pin_val_o == ocb_o));

    assert_pin_port_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode == 2'b00) |-> (pin_val_o == port_data));

    assert_dir_R12: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe_o == port_dir);

endmodule

bind tmr_cmp_out tmr_cmp_out_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .wave_mode (wave_mode),
    .out_mode  (out_mode),
    .cmp_val   (cmp_val),
    .force_stb (force_stb),
    .port_data (port_data),
    .port_dir  (port_dir),
    .cnt_o     (cnt_o),
    .ocb_o     (ocb_o),
    .pin_val_o (pin_val_o),
    .pin_oe_o  (pin_oe_o)
);

// File: tb/tb_tmr_cmp_out.sv
module tb_tmr_cmp_out;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] wave_mode = 2'b00;
    logic [1:0] out_mode = 2'b00;
    logic [7:0] cmp_val = 8'h00;
    logic       force_stb = 1'b0;
    logic       port_data = 1'b0;
    logic       port_dir = 1'b0;
    logic [7:0] cnt_o;
    logic       ocb_o;
    logic       pin_val_o;
    logic       pin_oe_o;

    int   n_chk = 0;
    int   n_bad = 0;
    logic [7:0] m_cnt = 8'h00;
    logic       m_up = 1'b1;
    logic       m_ocb = 1'b0;

    always #4 clk = ~clk;

    tmr_cmp_out dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wave_mode(wave_mode),
        .out_mode(out_mode), .cmp_val(cmp_val), .force_stb(force_stb),
        .port_data(port_data), .port_dir(port_dir), .cnt_o(cnt_o),
        .ocb_o(ocb_o), .pin_val_o(pin_val_o), .pin_oe_o(pin_oe_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic act_np(input logic [1:0] om, input logic cur);
        case (om)
            2'b00: return cur;
            2'b01: return ~cur;
            2'b10: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    // Reference model of one clock edge, written from the requirements.
    task automatic model_edge(input logic t, input logic [1:0] wm, input logic [1:0] om,
                              input logic [7:0] cv, input logic f);
        logic       mt;
        logic [7:0] nc;
        logic       nu;
        logic       no;
        mt = t && (m_cnt == cv);
        nc = m_cnt;
        nu = (wm == 2'b11) ? m_up : 1'b1;
        no = m_ocb;
        if (f && !wm[1]) no = act_np(om, m_ocb);
        else if (t) begin
            case (wm)
                2'b00, 2'b01: if (mt) no = act_np(om, m_ocb);
                2'b10: if (om[1]) begin
                    if (mt) no = (om == 2'b11);
                    else if (m_cnt == 8'h00) no = (om == 2'b10);
                end
                default: if (om[1] && mt) no = m_up ? (om == 2'b11) : (om == 2'b10);
            endcase
        end
        if (t) begin
            case (wm)
                2'b01: nc = mt ? 8'h00 : m_cnt + 8'h01;
                2'b11: begin
                    if (m_up) begin
                        if (m_cnt == 8'hFF) begin nc = 8'hFE; nu = 1'b0; end
                        else nc = m_cnt + 8'h01;
                    end else begin
                        if (m_cnt == 8'h00) begin nc = 8'h01; nu = 1'b1; end
                        else nc = m_cnt - 8'h01;
                    end
                end
                default: nc = m_cnt + 8'h01;
            endcase
        end
        m_cnt = nc;
        m_up  = nu;
        m_ocb = no;
    endtask

    task automatic step(input logic t, input logic [1:0] wm, input logic [1:0] om,
                        input logic [7:0] cv, input logic f, input logic pd, input logic pdir);
        string rc;
        string ro;
        tick = t; wave_mode = wm; out_mode = om; cmp_val = cv;
        force_stb = f; port_data = pd; port_dir = pdir;
        @(posedge clk);
        model_edge(t, wm, om, cv, f);
        @(negedge clk);
        if (!t) rc = "R2";
        else if (wm == 2'b01) rc = "R4";
        else if (wm == 2'b11) rc = "R5";
        else rc = "R3";
        if (f && !wm[1]) ro = "R9";
        else if (f) ro = "R10";
        else if (!t) ro = "R13";
        else if (!wm[1]) ro = "R6";
        else if (wm == 2'b10) ro = "R7";
        else ro = "R8";
        chk(rc, "cnt_o", int'(cnt_o), int'(m_cnt));
        chk(ro, "ocb_o", int'(ocb_o), int'(m_ocb));
        chk("R11", "pin_val_o", int'(pin_val_o), int'((om != 2'b00) ? m_ocb : pd));
        chk("R12", "pin_oe_o", int'(pin_oe_o), int'(pdir));
        tick = 1'b0;
        force_stb = 1'b0;
    endtask

    task automatic rand_run(input int n, input int wm_fixed, input logic small_cmp);
        logic [1:0] wm;
        logic [1:0] om;
        logic [7:0] cv;
        om = 2'b10;
        cv = 8'h40;
        for (int i = 0; i < n; i++) begin
            wm = (wm_fixed < 0) ? 2'($urandom_range(0, 3)) : 2'(wm_fixed);
            if ($urandom_range(0, 40) == 0) om = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 60) == 0)
                cv = small_cmp ? 8'($urandom_range(0, 12)) : 8'($urandom_range(0, 255));
            step($urandom_range(0, 9) < 8, wm, om, cv, $urandom_range(0, 19) == 0,
                 1'($urandom), 1'($urandom));
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset cnt_o", int'(cnt_o), 0);
        chk("R1", "reset ocb_o", int'(ocb_o), 0);
        rst_n = 1'b1;

        // Preset through force while the pin is an input, then enable the output (R9, R12, R11).
        step(1'b0, 2'b00, 2'b11, 8'h80, 1'b1, 1'b0, 1'b0);
        step(1'b0, 2'b00, 2'b11, 8'h80, 1'b0, 1'b0, 1'b1);
        // A new action value alone does not move the bit (R13).
        step(1'b0, 2'b00, 2'b10, 8'h80, 1'b0, 1'b0, 1'b1);
        // Force in the same cycle as a toggle match: the action applies once (R9).
        while (m_cnt != 8'h03) step(1'b1, 2'b00, 2'b01, 8'h03, 1'b0, 1'b0, 1'b1);
        step(1'b1, 2'b00, 2'b01, 8'h03, 1'b1, 1'b0, 1'b1);
        // Fast PWM with a compare value of 0: the match wins over the bottom event (R7).
        for (int i = 0; i < 600; i++) step(1'b1, 2'b10, 2'b10, 8'h00, 1'b0, 1'b0, 1'b1);
        // Force ignored in PWM modes (R10).
        step(1'b0, 2'b10, 2'b01, 8'h00, 1'b1, 1'b0, 1'b1);
        step(1'b0, 2'b11, 2'b11, 8'h00, 1'b1, 1'b0, 1'b1);
        // Phase-correct run through both turnarounds (R5, R8).
        for (int i = 0; i < 1100; i++) step(1'b1, 2'b11, 2'b11, 8'h20, 1'b0, 1'b1, 1'b1);

        rand_run(1500, 0, 1'b1);   // R3, R6
        rand_run(1500, 1, 1'b1);   // R4, R6
        rand_run(2000, 2, 1'b0);   // R7
        rand_run(2000, 3, 1'b0);   // R8
        rand_run(3000, -1, 1'b0);  // mixed modes, R2 and R13 by gaps in tick

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule